// File: doc/BRIEF.md
# DMA Channel Service Sequencer

This block is the control sequencer of a multi-channel DMA engine whose transfer descriptors live in an external local memory. It takes one pending channel at a time through a fixed pipeline. First it picks the winner among pending channels. It then reads that channel's descriptor in two halves. It makes one source read and one destination write on a simple system bus that can insert wait states. Finally it writes the updated descriptor back in two halves. Between the bus write and the writeback it re-reads the control word and raises an internal request for a linked channel when the descriptor asks for one.

The last writeback cycle also serves as the arbitration cycle for the next channel. The next winner therefore reads its first descriptor half in the very next cycle. With requests queued back to back, each service costs 4 entry cycles, the read data phase, the write data phase and 3 exit cycles. At zero wait states that is one completed service every 9 cycles.

Descriptor layout, used by both the sequencer and the memory it drives:
- Half 0 (memory address {channel, 0}) holds the source address in bits [AW-1:0] and the destination address in bits [2*AW-1:AW].
- Half 1 (memory address {channel, 1}) holds the remaining count in bits [CW-1:0], the link enable in bit CW and the linked channel number in bits [CW+LW:CW+1].

Top module: `dma_svc_seq`

## Requirements
- R1: While reset is high, and afterwards while no request is pending, done, link_fire, bus_aphase, bus_rd, bus_wr, tcd_re and tcd_we all stay low.
- R2: A request pulse on req[i] makes channel i pending. When several channels are pending, the lowest channel number is served first. Channels are served one at a time.
- R3: From idle, a request seen at a clock edge yields the done pulse 10 + read waits + write waits cycles later (one arbitration cycle plus 9).
- R4: With back-to-back pending channels and zero wait states, done pulses of successive services are exactly 9 cycles apart. The second-half writeback cycle of one channel is its successor's arbitration cycle, and the successor's half-0 read follows in the next cycle.
- R5: Every cycle that bus_ready is held low in the read data phase (bus_rd) or in the write data phase (bus_wr) adds exactly one cycle to the service, giving 9 + read waits + write waits.
- R6: A service does the following on the bus:
  - one address cycle (bus_aphase) at the source address;
  - a read data phase at the same address;
  - a write data phase at the destination address, carrying the word that was read.
  While bus_ready is low, bus_addr and bus_wdata are held.
- R7: Writeback stores half 0 with both addresses advanced by DW/8. It stores half 1 with the count reduced by one and the link fields unchanged.
- R8: done[i] pulses for exactly one cycle, only for the served channel, and only when its count goes from 1 to 0. A service that leaves a nonzero count gives no done pulse.
- R9: When the control word re-read after the bus write has its link enable set, link_fire pulses with link_ch equal to the linked channel. That channel joins the arbitration at the end of the current service, under the same lowest-number priority.
- R10: A channel's pending flag clears when its service completes. It is served again only after a new request or a link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NCH | Per-channel service request pulses |
| tcd_re | output | 1 | Descriptor memory read enable (data returned next cycle) |
| tcd_we | output | 1 | Descriptor memory write enable |
| tcd_addr | output | LW+1 | Descriptor word address {channel, half} |
| tcd_wdata | output | 2*AW | Descriptor write data |
| tcd_rdata | input | 2*AW | Descriptor read data, one cycle after tcd_re |
| bus_aphase | output | 1 | Source read address cycle |
| bus_rd | output | 1 | Read data phase active |
| bus_wr | output | 1 | Write data phase active |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, taken when bus_ready is high in the read data phase |
| bus_ready | input | 1 | Completes the current data phase; low inserts a wait state |
| done | output | NCH | One-cycle pulse when a channel's count reaches zero |
| link_fire | output | 1 | Pulse when the re-read control word requests a linked channel |
| link_ch | output | LW | Linked channel number, valid with link_fire |

## Verification
Sequencing faults show up in the spacing of done pulses. A state skipped or repeated shifts the gap away from 9 plus the injected waits within the very next service. A wrong arbitration mask or a wrong pending-clear shows up as an out-of-order, missing or repeated done pulse and bus write within one service period. Datapath faults appear at the next bus write address or data, or in the descriptor words stored two cycles after that write. Link faults appear as a missing link_fire, or as a linked channel served out of priority order one period later.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH0,
        S_FETCH1,
        S_PREP,
        S_RADDR,
        S_RDATA,
        S_WDATA,
        S_CHK,
        S_WB0,
        S_WB1
    } svc_state_e;

    function automatic logic arb_state(svc_state_e s);
        return (s == S_IDLE) || (s == S_WB1);
    endfunction

    function automatic logic tcd_read_state(svc_state_e s);
        return (s == S_FETCH0) || (s == S_FETCH1) || (s == S_CHK);
    endfunction

    function automatic logic second_half(svc_state_e s);
        return (s == S_FETCH1) || (s == S_CHK) || (s == S_WB1);
    endfunction

endpackage

// File: rtl/dma_seq_arb.sv
module dma_seq_arb #(
    parameter int NCH = 4,
    localparam int LW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] cand,
    output logic [NCH-1:0] grant,
    output logic [LW-1:0]  gidx,
    output logic           any
);
    logic [NCH-1:0] below;

    assign below[0] = 1'b0;
    generate
        for (genvar i = 1; i < NCH; i++) begin : g_chain
            assign below[i] = below[i-1] | cand[i-1];
        end
    endgenerate

    assign grant = cand & ~below;
    assign any   = |cand;

    always_comb begin
        gidx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (grant[i]) gidx = gidx | LW'(i);
        end
    end

    // R2: exactly one winner, and no lower-numbered candidate beside it
    a_r2_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        any |-> ($onehot(grant) && ((cand & (grant - NCH'(1))) == '0)));

endmodule

// File: rtl/dma_seq_dp.sv
module dma_seq_dp #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8,
    localparam int TW = 2 * AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_h0,
    input  logic          ld_h1,
    input  logic          cap_rd,
    input  logic [TW-1:0] tcd_rdata,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] saddr,
    output logic [AW-1:0] daddr,
    output logic [DW-1:0] rbuf,
    output logic          cnt_last,
    output logic [TW-1:0] wb_h0,
    output logic [TW-1:0] wb_h1
);
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    logic [TW-1:0] h0_q, h1_q;
    logic [DW-1:0] rbuf_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            h0_q   <= '0;
            h1_q   <= '0;
            rbuf_q <= '0;
        end else begin
            if (ld_h0)  h0_q   <= tcd_rdata;
            if (ld_h1)  h1_q   <= tcd_rdata;
            if (cap_rd) rbuf_q <= bus_rdata;
        end
    end

    assign saddr    = h0_q[AW-1:0];
    assign daddr    = h0_q[TW-1:AW];
    assign cnt      = h1_q[CW-1:0];
    assign rbuf     = rbuf_q;
    assign cnt_last = (cnt == CW'(1));
    assign wb_h0    = {daddr + STEP, saddr + STEP};
    assign wb_h1    = {h1_q[TW-1:CW], cnt - CW'(1)};

endmodule

// File: rtl/dma_svc_seq.sv
module dma_svc_seq
    import dma_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 8,
    localparam int LW  = $clog2(NCH),
    localparam int TW  = 2 * AW,
    localparam int TAW = LW + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] req,
    output logic           tcd_re,
    output logic           tcd_we,
    output logic [TAW-1:0] tcd_addr,
    output logic [TW-1:0]  tcd_wdata,
    input  logic [TW-1:0]  tcd_rdata,
    output logic           bus_aphase,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_ready,
    output logic [NCH-1:0] done,
    output logic           link_fire,
    output logic [LW-1:0]  link_ch
);
    svc_state_e     st_q, st_d;
    logic [LW-1:0]  ch_q, gidx;
    logic [NCH-1:0] pend_q, link_vec_q, link_vec_d, cur_oh, cand, grant, clr;
    logic           g_any, cnt_last, link_hit, rd_link_en;
    logic [LW-1:0]  rd_link_ch;
    logic [AW-1:0]  saddr, daddr;
    logic [DW-1:0]  rbuf;
    logic [TW-1:0]  wb_h0, wb_h1;

    // control word fields as returned by the re-read in the check cycle
    assign rd_link_en = tcd_rdata[CW];
    assign rd_link_ch = tcd_rdata[CW+LW:CW+1];
    assign link_hit   = (st_q == S_WB0) && rd_link_en;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign cur_oh[i]     = (ch_q == LW'(i));
            assign link_vec_d[i] = link_hit && (rd_link_ch == LW'(i));
            assign done[i]       = (st_q == S_WB1) && cnt_last && cur_oh[i];
        end
    endgenerate

    always_comb begin
        if (st_q == S_IDLE)     cand = pend_q;
        else if (st_q == S_WB1) cand = (pend_q & ~cur_oh) | link_vec_q;
        else                    cand = '0;
    end

    dma_seq_arb #(.NCH(NCH)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .cand  (cand),
        .grant (grant),
        .gidx  (gidx),
        .any   (g_any)
    );

    always_comb begin
        st_d = st_q;
        case (st_q)
            S_IDLE:   if (g_any) st_d = S_FETCH0;
            S_FETCH0: st_d = S_FETCH1;
            S_FETCH1: st_d = S_PREP;
            S_PREP:   st_d = S_RADDR;
            S_RADDR:  st_d = S_RDATA;
            S_RDATA:  if (bus_ready) st_d = S_WDATA;
            S_WDATA:  if (bus_ready) st_d = S_CHK;
            S_CHK:    st_d = S_WB0;
            S_WB0:    st_d = S_WB1;
            S_WB1:    st_d = g_any ? S_FETCH0 : S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    assign clr = (st_q == S_WB1) ? cur_oh : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            ch_q       <= '0;
            pend_q     <= '0;
            link_vec_q <= '0;
        end else begin
            st_q       <= st_d;
            if (arb_state(st_q) && g_any) ch_q <= gidx;
            pend_q     <= (pend_q & ~clr) | req | link_vec_q;
            link_vec_q <= link_vec_d;
        end
    end

    dma_seq_dp #(.AW(AW), .DW(DW), .CW(CW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ld_h0     (st_q == S_FETCH1),
        .ld_h1     (st_q == S_PREP),
        .cap_rd    ((st_q == S_RDATA) && bus_ready),
        .tcd_rdata (tcd_rdata),
        .bus_rdata (bus_rdata),
        .saddr     (saddr),
        .daddr     (daddr),
        .rbuf      (rbuf),
        .cnt_last  (cnt_last),
        .wb_h0     (wb_h0),
        .wb_h1     (wb_h1)
    );

    // descriptor memory port
    assign tcd_re    = tcd_read_state(st_q);
    assign tcd_we    = (st_q == S_WB0) || (st_q == S_WB1);
    assign tcd_addr  = {ch_q, second_half(st_q)};
    assign tcd_wdata = (st_q == S_WB0) ? wb_h0 : ((st_q == S_WB1) ? wb_h1 : '0);

    // system bus port
    assign bus_aphase = (st_q == S_RADDR);
    assign bus_rd     = (st_q == S_RDATA);
    assign bus_wr     = (st_q == S_WDATA);
    assign bus_addr   = bus_wr ? daddr : saddr;
    assign bus_wdata  = bus_wr ? rbuf : '0;

    assign link_fire  = link_hit;
    assign link_ch    = link_hit ? rd_link_ch : '0;

    // R6: address held through read wait states
    a_r6_hold_rd: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));
    // R6: address and data held through write wait states
    a_r6_hold_wr: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));
    // R5: a completed read data phase is followed at once by the write data phase
    a_r5_rd_then_wr: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_ready) |=> bus_wr);
    // R8: at most one done bit, and only during the second-half writeback
    a_r8_done_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done));
    a_r8_done_in_wb: assert property (@(posedge clk) disable iff (rst)
        (|done) |-> (tcd_we && tcd_addr[0]));
    // R1: memory port never reads and writes in one cycle
    a_r1_port_excl: assert property (@(posedge clk) disable iff (rst)
        !(tcd_re && tcd_we));
    // R4: a winner at final writeback reads its first half in the next cycle
    a_r4_overlap: assert property (@(posedge clk) disable iff (rst)
        ((st_q == S_WB1) && g_any) |=> (tcd_re && !tcd_addr[0]));
    // R9: a linked channel is a candidate in the following arbitration
    a_r9_link_joins: assert property (@(posedge clk) disable iff (rst)
        link_fire |=> ((st_q == S_WB1) && cand[$past(link_ch)]));

endmodule

// File: tb/tb_dma_svc_seq.sv
`timescale 1ns/1ps
module tb_dma_svc_seq;
    localparam int NCH = 4, AW = 16, DW = 16, CW = 8;
    localparam int LW = 2, TW = 32, TAW = 3;

    logic clk, rst;
    logic [NCH-1:0] req;
    logic tcd_re, tcd_we;
    logic [TAW-1:0] tcd_addr;
    logic [TW-1:0] tcd_wdata, tcd_rdata;
    logic bus_aphase, bus_rd, bus_wr, bus_ready;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic [NCH-1:0] done;
    logic link_fire;
    logic [LW-1:0] link_ch;

    dma_svc_seq #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) dut (
        .clk(clk), .rst(rst), .req(req),
        .tcd_re(tcd_re), .tcd_we(tcd_we), .tcd_addr(tcd_addr),
        .tcd_wdata(tcd_wdata), .tcd_rdata(tcd_rdata),
        .bus_aphase(bus_aphase), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .done(done), .link_fire(link_fire), .link_ch(link_ch)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [DW-1:0] rfun(logic [AW-1:0] a);
        return a ^ 16'h5A3C;
    endfunction
    function automatic logic [TW-1:0] h1word(int cnt, bit len, int lch);
        return (TW'(lch) << (CW + 1)) | (TW'(len) << CW) | TW'(cnt);
    endfunction
    assign bus_rdata = rfun(bus_addr);

    // descriptor memory model with host load port
    logic [TW-1:0] tmem [0:2*NCH-1];
    logic host_we;
    logic [TAW-1:0] host_addr;
    logic [TW-1:0] host_data;
    always @(posedge clk) begin
        if (host_we) tmem[host_addr] <= host_data;
        else if (tcd_we) tmem[tcd_addr] <= tcd_wdata;
        if (tcd_re) tcd_rdata <= tmem[tcd_addr];
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    int ws_rd = 0, ws_wr = 0;
    int rcnt = 0, wcnt = 0;
    int ndone = 0, nwr = 0, nlink = 0, hold_err = 0, multi_done = 0;
    int done_ch_log [0:255];
    int done_cyc_log [0:255];
    logic [AW-1:0] wr_addr_log [0:255];
    logic [DW-1:0] wr_data_log [0:255];
    int link_log [0:63];
    bit prev_stall = 0;
    logic [AW-1:0] prev_addr;

    // bus slave, stall watcher and output logger
    always @(negedge clk) begin
        if (rst) begin
            bus_ready = 1'b0; rcnt = 0; wcnt = 0; prev_stall = 0;
        end else begin
            bus_ready = 1'b0;
            if (bus_rd) begin bus_ready = (rcnt == ws_rd); rcnt++; end else rcnt = 0;
            if (bus_wr) begin bus_ready = (wcnt == ws_wr); wcnt++; end else wcnt = 0;
            if (prev_stall && bus_addr != prev_addr) hold_err++;
            prev_stall = (bus_rd || bus_wr) && !bus_ready;
            prev_addr = bus_addr;
            if (bus_wr && bus_ready && nwr < 256) begin
                wr_addr_log[nwr] = bus_addr; wr_data_log[nwr] = bus_wdata; nwr++;
            end
            if (|done && ndone < 256) begin
                if ($countones(done) != 1) multi_done++;
                for (int i = 0; i < NCH; i++) if (done[i]) done_ch_log[ndone] = i;
                done_cyc_log[ndone] = cyc; ndone++;
            end
            if (link_fire && nlink < 64) begin link_log[nlink] = int'(link_ch); nlink++; end
        end
    end

    task automatic check(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic tcd_put(int a, logic [TW-1:0] d);
        host_addr = TAW'(a); host_data = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic pulse_req(logic [NCH-1:0] m, output int c0);
        req = m; c0 = cyc;
        @(negedge clk);
        req = '0;
    endtask

    task automatic wait_done(int target);
        for (int t = 0; t < 600 && ndone < target; t++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    logic [AW-1:0] sa [0:NCH-1];
    logic [AW-1:0] da [0:NCH-1];

    // batch of count-1 services on the channels in mask, no links
    task automatic run_batch(logic [NCH-1:0] mask, int wr, int ww);
        int nd0, nw0, n, c0, k;
        ws_rd = wr; ws_wr = ww;
        for (int ch = 0; ch < NCH; ch++) if (mask[ch]) begin
            sa[ch] = AW'($urandom) & 16'hFFFE;
            da[ch] = AW'($urandom) & 16'hFFFE;
            tcd_put(2*ch, {da[ch], sa[ch]});
            tcd_put(2*ch+1, h1word(1, 0, 0));
        end
        nd0 = ndone; nw0 = nwr; n = $countones(mask);
        pulse_req(mask, c0);
        wait_done(nd0 + n);
        check(ndone - nd0 == n, "R8 done count", ndone - nd0, n);
        k = 0;
        for (int ch = 0; ch < NCH; ch++) if (mask[ch]) begin
            check(done_ch_log[nd0+k] == ch, "R2 service order", done_ch_log[nd0+k], ch);
            if (k == 0)
                check(done_cyc_log[nd0] - c0 == 10 + wr + ww, "R3 idle latency",
                      done_cyc_log[nd0] - c0, 10 + wr + ww);
            else if (wr + ww == 0)
                check(done_cyc_log[nd0+k] - done_cyc_log[nd0+k-1] == 9, "R4 period",
                      done_cyc_log[nd0+k] - done_cyc_log[nd0+k-1], 9);
            else
                check(done_cyc_log[nd0+k] - done_cyc_log[nd0+k-1] == 9 + wr + ww, "R5 waited period",
                      done_cyc_log[nd0+k] - done_cyc_log[nd0+k-1], 9 + wr + ww);
            check(wr_addr_log[nw0+k] == da[ch], "R6 write addr", wr_addr_log[nw0+k], da[ch]);
            check(wr_data_log[nw0+k] == rfun(sa[ch]), "R6 write data", wr_data_log[nw0+k], rfun(sa[ch]));
            check(tmem[2*ch] == {da[ch] + 16'd2, sa[ch] + 16'd2}, "R7 half0",
                  int'(tmem[2*ch][15:0]), int'(sa[ch] + 16'd2));
            check(tmem[2*ch+1] == h1word(0, 0, 0), "R7 half1", int'(tmem[2*ch+1]), 0);
            k++;
        end
        check(nwr - nw0 == n, "R10 one write per request", nwr - nw0, n);
    endtask

    initial begin
        int c0, nd0, nw0, nl0;
        rst = 1'b1; req = '0; host_we = 1'b0; host_addr = '0; host_data = '0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 2*NCH; i++) tmem[i] = '0;
        repeat (3) @(negedge clk);
        check(done == 0 && !link_fire, "R1 reset outputs", int'(done), 0);
        check(!(bus_aphase || bus_rd || bus_wr || tcd_re || tcd_we), "R1 reset ports idle",
              int'({bus_aphase, bus_rd, bus_wr, tcd_re, tcd_we}), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(!(bus_aphase || bus_rd || bus_wr || tcd_re || tcd_we) && done == 0, "R1 idle after reset",
              int'({bus_aphase, bus_rd, bus_wr, tcd_re, tcd_we}), 0);

        // directed: all channels, zero waits, then waits on both phases
        run_batch(4'b1111, 0, 0);
        run_batch(4'b1001, 3, 2);
        // random batches
        for (int b = 0; b < 8; b++) begin
            logic [NCH-1:0] m;
            m = NCH'($urandom);
            if ($countones(m) < 2) m = m | 4'b0110;
            run_batch(m, int'($urandom % 4), int'($urandom % 4));
        end

        // multi-pass count: done only on the pass that reaches zero
        ws_rd = 1; ws_wr = 0;
        sa[2] = 16'h0100; da[2] = 16'h0800;
        tcd_put(4, {da[2], sa[2]});
        tcd_put(5, h1word(3, 0, 0));
        for (int rep = 0; rep < 3; rep++) begin
            nd0 = ndone; nw0 = nwr;
            pulse_req(4'b0100, c0);
            repeat (30) @(negedge clk);
            check(nwr - nw0 == 1, "R10 single service", nwr - nw0, 1);
            check(wr_addr_log[nw0] == da[2] + AW'(2*rep), "R6 stepped dest",
                  wr_addr_log[nw0], da[2] + AW'(2*rep));
            check(ndone - nd0 == (rep == 2 ? 1 : 0), "R8 done only at zero", ndone - nd0, rep == 2 ? 1 : 0);
            check(tmem[5] == h1word(2 - rep, 0, 0), "R7 count writeback", int'(tmem[5][7:0]), 2 - rep);
            check(tmem[4] == {da[2] + AW'(2*rep+2), sa[2] + AW'(2*rep+2)}, "R7 address step",
                  int'(tmem[4][15:0]), int'(sa[2] + AW'(2*rep+2)));
        end

        // link: ch1 links to ch0 while ch2 also pends; order 1, 0, 2
        ws_rd = 0; ws_wr = 0;
        tcd_put(0, {16'h2000, 16'h1000});
        tcd_put(1, h1word(1, 0, 0));
        tcd_put(2, {16'h2100, 16'h1100});
        tcd_put(3, h1word(1, 1, 0));
        tcd_put(4, {16'h2200, 16'h1200});
        tcd_put(5, h1word(1, 0, 0));
        nd0 = ndone; nl0 = nlink;
        pulse_req(4'b0110, c0);
        wait_done(nd0 + 3);
        check(ndone - nd0 == 3, "R9 services with link", ndone - nd0, 3);
        check(done_ch_log[nd0] == 1, "R9 first", done_ch_log[nd0], 1);
        check(done_ch_log[nd0+1] == 0, "R9 linked beats pending", done_ch_log[nd0+1], 0);
        check(done_ch_log[nd0+2] == 2, "R9 pending last", done_ch_log[nd0+2], 2);
        check(done_cyc_log[nd0+1] - done_cyc_log[nd0] == 9, "R9 R4 link period",
              done_cyc_log[nd0+1] - done_cyc_log[nd0], 9);
        check(nlink - nl0 == 1, "R9 link pulse count", nlink - nl0, 1);
        check(link_log[nl0] == 0, "R9 link channel", link_log[nl0], 0);
        check(tmem[3] == h1word(0, 1, 0), "R7 link fields kept", int'(tmem[3]), int'(h1word(0, 1, 0)));

        check(hold_err == 0, "R6 hold while stalled", hold_err, 0);
        check(multi_done == 0, "R8 single done bit", multi_done, 0);
        repeat (10) @(negedge clk);
        check(!(bus_rd || bus_wr || tcd_re) && done == 0, "R1 idle at end",
              int'({bus_rd, bus_wr, tcd_re}), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule